// File: doc/BRIEF.md
# Real-Time Clock Interrupt Request Controller

This block gathers the event strobes of a real-time clock into one interrupt request line. Six sources feed it. Three are core sources: a periodic tick, an alarm hit and the end of each seconds update. The other three are extra event inputs. Each source owns a sticky flag and an enable bit. The flags record events whether or not they are enabled. An enabled flag, and only an enabled flag, pulls the active-low request line.

The alarm comparator lives inside the block. On each seconds update it compares the hours, minutes and seconds fields of the current time with three alarm fields. Any alarm field whose two top bits are both set counts as a wildcard. Software learns that the clock raised the request by reading the status word and seeing the summary bit. That same read clears every flag and releases the line.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset every flag and every enable bit is 0, `stat_rdata_o` is all zero, `irq_oe_o` is 0 and `irq_n_o` is 1.
- R2: A one-cycle strobe on an event input sets its flag on the next clock edge. The flag then holds until a status read. Bit positions in `stat_rdata_o` are: 0 periodic, 1 alarm, 2 seconds update, 3 to 5 the extra events `ext_evt_i[0..2]`.
- R3: A flag sets even while its enable bit is 0, and that flag does not drive the request line.
- R4: Bit 6 of `stat_rdata_o` is the OR of (flag AND enable) over all six sources. `irq_oe_o` equals this bit and `irq_n_o` is its inverse.
- R5: A cycle with `stat_rd_i` high returns the current flags and summary on `stat_rdata_o`. All flags clear on that edge, which releases the line.
- R6: An event strobe in the same cycle as a status read is kept. Its flag reads 1 after the read, while the read data shows the value from before the event.
- R7: A seconds-update strobe sets the alarm flag when the hours, minutes and seconds all equal their alarm fields. Otherwise it sets only the update flag.
- R8: An alarm field with bits [7:6] equal to 2'b11 matches any value of its time field.
- R9: The alarm flag sets again on every seconds-update strobe for as long as the masked match holds, including after a read has cleared it.
- R10: The enable bits change only on a cycle with `en_we_i` high, which loads `en_wdata_i` (same bit order as the flags). A write leaves the flags unchanged.
- R11: Turning on the enable of a flag that is already pending asserts the request on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| per_tick_i | input | 1 | Periodic event strobe |
| sec_tick_i | input | 1 | Seconds-update-complete strobe |
| ext_evt_i | input | 3 | Extra event strobes |
| tm_hr_i | input | 8 | Current hours field |
| tm_min_i | input | 8 | Current minutes field |
| tm_sec_i | input | 8 | Current seconds field |
| al_hr_i | input | 8 | Alarm hours field |
| al_min_i | input | 8 | Alarm minutes field |
| al_sec_i | input | 8 | Alarm seconds field |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 6 | New enable bits |
| stat_rd_i | input | 1 | Status read strobe (clears flags) |
| stat_rdata_o | output | 7 | Summary bit and six flags |
| irq_n_o | output | 1 | Request level, low when asserted |
| irq_oe_o | output | 1 | Drive enable of the open-drain request |

## Verification
Several properties are checked on every cycle. The periodic and update strobes always set their flags. With no status read, flags never fall. A read with no events leaves the flags empty. The request is driven only when some pending flag is enabled. Enables never change without a write, and an all-wildcard alarm always hits. Some behaviour needs the bench's scenarios and its model: the exact alarm compare across matching, mismatching and partly masked fields, the repeat of the alarm across reads, an event that lands in a read cycle, and the request rising when an enable is written over an already pending flag.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int FLD_W    = 8;
    localparam int NUM_FLD  = 3;
    localparam int NUM_CORE = 3;
    localparam int SRC_PER  = 0;
    localparam int SRC_ALM  = 1;
    localparam int SRC_UPD  = 2;
    localparam logic [1:0] WILD_TAG = 2'b11;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_irq_pkg::*;
#(
    parameter int W    = FLD_W,
    parameter int NFLD = NUM_FLD
) (
    input  logic [NFLD*W-1:0] time_i,
    input  logic [NFLD*W-1:0] alarm_i,
    output logic              match_o
);
    logic [NFLD-1:0] fld_ok;

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        logic [W-1:0] t_f, a_f;
        assign t_f = time_i[g*W +: W];
        assign a_f = alarm_i[g*W +: W];
        // wildcard when the two top bits of the alarm field are both set
        assign fld_ok[g] = (a_f[W-1 -: 2] == WILD_TAG) || (a_f == t_f);
    end

    assign match_o = &fld_ok;
endmodule

// File: rtl/rtc_irq_summary.sv
module rtc_irq_summary #(
    parameter int N = 6
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         pend_o
);
    assign pend_o = |(flag_i & en_i);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int NUM_EXT = 3,
    localparam int NSRC   = NUM_CORE + NUM_EXT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               per_tick_i,
    input  logic               sec_tick_i,
    input  logic [NUM_EXT-1:0] ext_evt_i,
    input  logic [FLD_W-1:0]   tm_hr_i,
    input  logic [FLD_W-1:0]   tm_min_i,
    input  logic [FLD_W-1:0]   tm_sec_i,
    input  logic [FLD_W-1:0]   al_hr_i,
    input  logic [FLD_W-1:0]   al_min_i,
    input  logic [FLD_W-1:0]   al_sec_i,
    input  logic               en_we_i,
    input  logic [NSRC-1:0]    en_wdata_i,
    input  logic               stat_rd_i,
    output logic [NSRC:0]      stat_rdata_o,
    output logic               irq_n_o,
    output logic               irq_oe_o
);
    typedef struct packed {
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] en;
    } irq_state_t;

    irq_state_t      st_d, st_q;
    logic [NSRC-1:0] flag_q, en_q, set_vec;
    logic            alm_hit, pend;

    rtc_alarm_cmp #(.W(FLD_W), .NFLD(NUM_FLD)) u_alarm (
        .time_i  ({tm_hr_i, tm_min_i, tm_sec_i}),
        .alarm_i ({al_hr_i, al_min_i, al_sec_i}),
        .match_o (alm_hit)
    );

    assign flag_q = st_q.flag;
    assign en_q   = st_q.en;

    rtc_irq_summary #(.N(NSRC)) u_sum (
        .flag_i (flag_q),
        .en_i   (en_q),
        .pend_o (pend)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_PER] = per_tick_i;
        set_vec[SRC_ALM] = sec_tick_i & alm_hit;
        set_vec[SRC_UPD] = sec_tick_i;
        set_vec[NUM_CORE +: NUM_EXT] = ext_evt_i;

        st_d = st_q;
        if (stat_rd_i) begin
            st_d.flag = '0;
        end
        // a new event wins over the clear of a simultaneous read
        st_d.flag = st_d.flag | set_vec;
        if (en_we_i) begin
            st_d.en = en_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_rdata_o = {pend, flag_q};
    assign irq_oe_o     = pend;
    assign irq_n_o      = ~pend;
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk
    import rtc_irq_pkg::*;
#(
    parameter int NUM_EXT = 3,
    localparam int NSRC   = NUM_CORE + NUM_EXT
) (
    input logic               clk,
    input logic               rst_n,
    input logic               per_tick_i,
    input logic               sec_tick_i,
    input logic [NUM_EXT-1:0] ext_evt_i,
    input logic [FLD_W-1:0]   al_hr_i,
    input logic [FLD_W-1:0]   al_min_i,
    input logic [FLD_W-1:0]   al_sec_i,
    input logic               en_we_i,
    input logic               stat_rd_i,
    input logic [NSRC:0]      stat_rdata_o,
    input logic               irq_n_o,
    input logic               irq_oe_o,
    input logic [NSRC-1:0]    en_q
);
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (stat_rdata_o == '0 && !irq_oe_o));

    a_r2_per_sets: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick_i |=> stat_rdata_o[SRC_PER]);

    a_r2_upd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_i |=> stat_rdata_o[SRC_UPD]);

    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd_i |=> ((stat_rdata_o[NSRC-1:0] & $past(stat_rdata_o[NSRC-1:0]))
                        == $past(stat_rdata_o[NSRC-1:0])));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !per_tick_i && !sec_tick_i && ext_evt_i == '0)
        |=> stat_rdata_o[NSRC-1:0] == '0);

    a_r3_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe_o |-> ((stat_rdata_o[NSRC-1:0] & en_q) != '0));

    a_r4_pin_pair: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe_o != irq_n_o);

    a_r10_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we_i |=> $stable(en_q));

    a_r8_all_wild: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick_i && al_hr_i[7:6] == WILD_TAG && al_min_i[7:6] == WILD_TAG
         && al_sec_i[7:6] == WILD_TAG) |=> stat_rdata_o[SRC_ALM]);
endmodule

bind rtc_irq_ctrl rtc_irq_chk #(.NUM_EXT(NUM_EXT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .per_tick_i   (per_tick_i),
    .sec_tick_i   (sec_tick_i),
    .ext_evt_i    (ext_evt_i),
    .al_hr_i      (al_hr_i),
    .al_min_i     (al_min_i),
    .al_sec_i     (al_sec_i),
    .en_we_i      (en_we_i),
    .stat_rd_i    (stat_rd_i),
    .stat_rdata_o (stat_rdata_o),
    .irq_n_o      (irq_n_o),
    .irq_oe_o     (irq_oe_o),
    .en_q         (en_q)
);

// File: tb/rtc_irq_ctrl_bench.sv
module rtc_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       per_tick = 1'b0, sec_tick = 1'b0, en_we = 1'b0, stat_rd = 1'b0;
    logic [2:0] ext_evt = '0;
    logic [7:0] tm_hr = '0, tm_min = '0, tm_sec = '0;
    logic [7:0] al_hr = '0, al_min = '0, al_sec = '0;
    logic [5:0] en_wdata = '0;
    logic [6:0] stat_rdata;
    logic       irq_n, irq_oe;

    int n_chk = 0, n_fail = 0;
    logic [5:0] mflag = '0, men = '0;
    logic [6:0] exp_q[$];

    always #2 clk = ~clk;

    rtc_irq_ctrl u_rtc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .per_tick_i(per_tick), .sec_tick_i(sec_tick),
        .ext_evt_i(ext_evt), .tm_hr_i(tm_hr), .tm_min_i(tm_min), .tm_sec_i(tm_sec),
        .al_hr_i(al_hr), .al_min_i(al_min), .al_sec_i(al_sec), .en_we_i(en_we),
        .en_wdata_i(en_wdata), .stat_rd_i(stat_rd), .stat_rdata_o(stat_rdata),
        .irq_n_o(irq_n), .irq_oe_o(irq_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] mexp();
        return {|(mflag & men), mflag};
    endfunction

    function automatic logic fld_ok(input logic [7:0] a, input logic [7:0] t);
        return (a[7:6] == 2'b11) || (a == t);
    endfunction

    task automatic observe(input string req);
        chk({req, " status"}, 32'(stat_rdata), 32'(mexp()));
        chk({req, " irq_oe"}, 32'(irq_oe), 32'(|(mflag & men)));
        chk({req, " irq_n"}, 32'(irq_n), 32'(~|(mflag & men)));
    endtask

    task automatic ev(input logic p, input logic s, input logic [2:0] x);
        @(negedge clk);
        per_tick = p; sec_tick = s; ext_evt = x;
        @(negedge clk);
        per_tick = 0; sec_tick = 0; ext_evt = '0;
        mflag[0] |= p;
        if (s) begin
            mflag[2] = 1'b1;
            if (fld_ok(al_hr, tm_hr) && fld_ok(al_min, tm_min) && fld_ok(al_sec, tm_sec))
                mflag[1] = 1'b1;
        end
        mflag[5:3] |= x;
    endtask

    // driver: pushes the expected read word, then performs the read
    task automatic rd(input logic [2:0] x);
        @(negedge clk);
        exp_q.push_back(mexp());
        stat_rd = 1'b1; ext_evt = x;
        @(negedge clk);
        stat_rd = 1'b0; ext_evt = '0;
        mflag = {x, 3'b000};
    endtask

    task automatic wr_en(input logic [5:0] v);
        @(negedge clk);
        en_we = 1'b1; en_wdata = v;
        @(negedge clk);
        en_we = 1'b0;
        men = v;
    endtask

    // monitor: compares read data against the scoreboard in the read cycle
    always @(negedge clk) begin
        #1;
        if (stat_rd) begin
            if (exp_q.size() == 0) chk("R5 scoreboard underflow", 1, 0);
            else chk("R5 read data", 32'(stat_rdata), 32'(exp_q.pop_front()));
        end
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        observe("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        observe("R1 after release");

        ev(1, 0, '0);                       // periodic, disabled
        observe("R2 R3 periodic flag without irq");
        rd('0);
        observe("R5 cleared after read");

        wr_en(6'b000001);
        observe("R10 write leaves flags");
        ev(1, 0, '0);
        observe("R4 enabled periodic drives irq");
        rd('0);
        observe("R5 read releases irq");

        tm_hr = 8'h12; tm_min = 8'h30; tm_sec = 8'h45;
        al_hr = 8'h12; al_min = 8'h30; al_sec = 8'h45;
        ev(0, 1, '0);
        observe("R7 R3 exact alarm match, alarm disabled");
        wr_en(6'b000011);
        observe("R11 enable over pending alarm");
        rd('0);

        tm_sec = 8'h46;
        ev(0, 1, '0);
        observe("R7 seconds mismatch gives only update flag");
        rd('0);

        al_sec = 8'hC0;
        ev(0, 1, '0);
        observe("R8 wildcard seconds");
        rd('0);
        al_hr = 8'hFF; al_min = 8'hC5; tm_hr = 8'h07; tm_min = 8'h59;
        ev(0, 1, '0);
        observe("R8 all fields wildcard");
        rd('0);
        ev(0, 1, '0);
        observe("R9 alarm repeats next second");
        rd('0);
        al_min = 8'h58;
        ev(0, 1, '0);
        observe("R7 minutes mismatch");
        rd('0);

        ev(0, 0, 3'b101);
        observe("R2 extra events set flags");
        rd(3'b010);                          // event during read
        observe("R6 event in read cycle kept");
        wr_en(6'b010000);
        observe("R11 R10 enabling pending extra flag");
        rd('0);
        observe("R5 final clear");

        repeat (3) @(negedge clk);
        chk("R5 scoreboard drained", 32'(exp_q.size()), 0);
        finish_run();
    end
endmodule